// File: doc/BRIEF.md
# Slot-Weighted Dispatch Group Tracker

The tracker models how a stream of issued instructions fills fixed-capacity dispatch groups. Each instruction taken into the current group comes with a 5-bit class code and a few flags. The block turns the class into a slot weight of 1, 2 or 4 and a "must lead" property. It keeps a running slot count, a branch count and a mask of occupied member positions. An upstream picker presents one candidate per cycle and gets three answers back: whether the candidate should give way to another instruction, whether it carries a same-group hazard, and how many filler no-ops must be emitted ahead of it.

The picker commits work through two plain single-cycle strobes. One accepts an instruction into the group. The other inserts a no-op. Neither port applies back-pressure, because the tracker takes every strobe in the cycle it is raised. When both strobes are raised together, the accept is applied first and the no-op is applied to the result. The terminating-no-op mode bit selects between two padding policies. In one, a single no-op closes the group. In the other, padding no-ops each take a slot.

Class encoding (5 bits):
- 0 and 25–31 are plain, weight 1.
- 1–11 are divides and update-form or algebraic loads and stores, weight 2.
- 12–20 are indexed-update, reserve/conditional and condition-register move forms, weight 4.
- 21–24 are condition-register logicals and reads and special-register writes, weight 1 but must lead.

Top module: `dgroup_tracker`

## Requirements
- R1: Class codes 1–11 weigh 2 slots, codes 12–20 weigh 4 slots, and all other codes weigh 1 slot.
- R2: A weight-1 class with the record flag set is promoted to weight 2.
- R3: Any class weighing more than 1 slot must lead a group, and so must codes 21–24 at weight 1.
- R4: Accepting an instruction while the slot count is 5, or accepting a branch while the branch count is 1, clears the slot count, the branch count and the member mask, and does not count that instruction.
- R5: A must-lead instruction accepted with a nonzero slot count starts a fresh group (counts and mask cleared) and then adds its own weight.
- R6: Any other accept adds the weight to the slot count (saturating at 15), shifts a 1 into the member mask from bit 0, and increments the branch count for a branch.
- R7: `hazard` is high when the candidate is valid, flagged conflicting, and is a load or a branch. `filler_count` is nonzero only with `hazard` and a slot count below 6. In that case it is 1 in terminating mode and 5 minus the slot count otherwise.
- R8: A no-op insertion closes the group (all state cleared) in terminating mode or when the slot count equals 6. Otherwise it adds one slot and shifts a 1 into the member mask.
- R9: `prefer_other` is high exactly when a valid candidate must lead and the slot count is nonzero.
- R10: With both strobes in one cycle, the accept is applied first and the no-op is applied to the state the accept produced.
- R11: A synchronous reset clears the slot count, the branch count and the member mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cand_valid | input | 1 | A candidate is being evaluated |
| cand_class | input | 5 | Candidate class code |
| cand_record | input | 1 | Candidate is a record (flag-setting) form |
| cand_load | input | 1 | Candidate is a load |
| cand_branch | input | 1 | Candidate is a branch |
| cand_conflict | input | 1 | Candidate depends on a store or counter write already in the group |
| term_noop_mode | input | 1 | A single no-op terminates a group |
| acc_valid | input | 1 | Strobe: accept an instruction into the group |
| acc_class | input | 5 | Accepted instruction class code |
| acc_record | input | 1 | Accepted instruction is a record form |
| acc_branch | input | 1 | Accepted instruction is a branch |
| noop_valid | input | 1 | Strobe: insert a no-op |
| hazard | output | 1 | Candidate has a same-group conflict |
| prefer_other | output | 1 | Picker should choose a different candidate |
| filler_count | output | 3 | No-ops needed before the candidate |
| slot_count | output | 4 | Slots used in the current group |
| branch_count | output | 2 | Branches in the current group |
| member_mask | output | 8 | Occupied member positions |

## Verification
The accept strobe and the no-op strobe can land in the same cycle. Their effects then chain: the accept may close or restart the group, and the no-op acts on that result. The test provokes this with directed cycles, one at slot count 0 under a weight-4 accept and one at slot count 5 where the accept itself closes the group. Random traffic also raises both strobes together often. The expected state for each of these cycles comes from a bench model that applies the accept rule and then the no-op rule, and it is compared with the count, branch and mask outputs on the following cycle.

// File: rtl/dgt_pkg.sv
package dgt_pkg;
  localparam int CLASS_W     = 5;
  localparam int SLOT_W      = 4;
  localparam int WEIGHT_W    = 3;
  localparam int FILL_W      = 3;
  localparam int BR_W        = 2;
  localparam int MEMBERS     = 8;
  localparam int GROUP_CLOSE = 5;
  localparam int NOOP_CLOSE  = 6;

  localparam int CLS_DUAL_LO = 1;
  localparam int CLS_DUAL_HI = 11;
  localparam int CLS_QUAD_LO = 12;
  localparam int CLS_QUAD_HI = 20;
  localparam int CLS_LEAD_LO = 21;
  localparam int CLS_LEAD_HI = 24;

  localparam int SLOT_MAX = (1 << SLOT_W) - 1;

  typedef logic [CLASS_W-1:0]  class_t;
  typedef logic [SLOT_W-1:0]   slot_t;
  typedef logic [WEIGHT_W-1:0] weight_t;
  typedef logic [MEMBERS-1:0]  members_t;

  typedef struct packed {
    weight_t weight;
    logic    lead;
  } cls_info_t;

  function automatic slot_t slot_sat_add(input slot_t a, input weight_t w);
    logic [SLOT_W:0] s;
    s = {1'b0, a} + {{(SLOT_W + 1 - WEIGHT_W){1'b0}}, w};
    if (s > (SLOT_W + 1)'(SLOT_MAX)) return slot_t'(SLOT_MAX);
    return s[SLOT_W-1:0];
  endfunction
endpackage

// File: rtl/dgt_class_decode.sv
module dgt_class_decode
  import dgt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  class_t    cls,
  input  logic      record,
  output cls_info_t info
);
  logic    in_dual, in_quad, in_lead;
  weight_t base_w;

  always_comb begin
    in_dual = (cls >= CLASS_W'(CLS_DUAL_LO)) && (cls <= CLASS_W'(CLS_DUAL_HI));
    in_quad = (cls >= CLASS_W'(CLS_QUAD_LO)) && (cls <= CLASS_W'(CLS_QUAD_HI));
    in_lead = (cls >= CLASS_W'(CLS_LEAD_LO)) && (cls <= CLASS_W'(CLS_LEAD_HI));
    if (in_quad)      base_w = WEIGHT_W'(4);
    else if (in_dual) base_w = WEIGHT_W'(2);
    else              base_w = WEIGHT_W'(1);
    info.weight = (record && base_w == WEIGHT_W'(1)) ? WEIGHT_W'(2) : base_w;
    info.lead   = (info.weight != WEIGHT_W'(1)) || in_lead;
  end

  assert_weight_legal_R1: assert property (@(posedge clk) disable iff (rst)
    en |-> (info.weight == 3'd1 || info.weight == 3'd2 || info.weight == 3'd4));
  assert_record_promote_R2: assert property (@(posedge clk) disable iff (rst)
    (en && record) |-> (info.weight != 3'd1));
  assert_multi_leads_R3: assert property (@(posedge clk) disable iff (rst)
    (en && info.weight != 3'd1) |-> info.lead);
endmodule

// File: rtl/dgt_filler_calc.sv
module dgt_filler_calc
  import dgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  slot_t             slot,
  input  logic              cand_valid,
  input  logic              cand_load,
  input  logic              cand_branch,
  input  logic              cand_conflict,
  input  logic              term_mode,
  output logic              hazard,
  output logic [FILL_W-1:0] filler
);
  slot_t room;
  logic  can_pad;

  always_comb begin
    hazard  = cand_valid && cand_conflict && (cand_load || cand_branch);
    can_pad = slot < SLOT_W'(NOOP_CLOSE);
    room    = SLOT_W'(GROUP_CLOSE) - slot;
    if (!hazard || !can_pad) filler = '0;
    else if (term_mode)      filler = FILL_W'(1);
    else                     filler = FILL_W'(room);
  end

  assert_filler_range_R7: assert property (@(posedge clk) disable iff (rst)
    filler <= 3'd5);
  assert_filler_needs_hazard_R7: assert property (@(posedge clk) disable iff (rst)
    !hazard |-> filler == '0);
  assert_filler_term_one_R7: assert property (@(posedge clk) disable iff (rst)
    (hazard && term_mode && slot < 4'd6) |-> filler == 3'd1);
endmodule

// File: rtl/dgt_group_state.sv
module dgt_group_state
  import dgt_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            term_mode,
  input  logic            acc_valid,
  input  logic            acc_branch,
  input  cls_info_t       acc_info,
  input  logic            noop_valid,
  output slot_t           slot_q,
  output logic [BR_W-1:0] br_q,
  output members_t        mem_q
);
  slot_t           s_acc, s_nxt;
  logic [BR_W-1:0] b_acc, b_nxt;
  members_t        m_acc, m_nxt;
  logic            acc_close, acc_restart, noop_close;

  // stage 1: accept
  always_comb begin
    s_acc = slot_q;
    b_acc = br_q;
    m_acc = mem_q;
    acc_close   = (slot_q == SLOT_W'(GROUP_CLOSE)) || (acc_branch && br_q == BR_W'(1));
    acc_restart = acc_info.lead && (slot_q != '0);
    if (acc_valid) begin
      if (acc_close) begin
        s_acc = '0;
        b_acc = '0;
        m_acc = '0;
      end else begin
        if (acc_restart) begin
          s_acc = '0;
          b_acc = '0;
          m_acc = '0;
        end
        s_acc = slot_sat_add(s_acc, acc_info.weight);
        m_acc = {m_acc[MEMBERS-2:0], 1'b1};
        if (acc_branch) b_acc = b_acc + BR_W'(1);
      end
    end
  end

  // stage 2: no-op applied to the result of stage 1
  always_comb begin
    s_nxt = s_acc;
    b_nxt = b_acc;
    m_nxt = m_acc;
    noop_close = term_mode || (s_acc == SLOT_W'(NOOP_CLOSE));
    if (noop_valid) begin
      if (noop_close) begin
        s_nxt = '0;
        b_nxt = '0;
        m_nxt = '0;
      end else begin
        s_nxt = slot_sat_add(s_acc, WEIGHT_W'(1));
        m_nxt = {m_acc[MEMBERS-2:0], 1'b1};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
      br_q   <= '0;
      mem_q  <= '0;
    end else begin
      slot_q <= s_nxt;
      br_q   <= b_nxt;
      mem_q  <= m_nxt;
    end
  end

  assert_reset_clears_R11: assert property (@(posedge clk)
    rst |=> (slot_q == '0 && br_q == '0 && mem_q == '0));
  assert_full_close_R4: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !noop_valid && slot_q == 4'd5) |=> (slot_q == '0 && mem_q == '0));
  assert_branch_limit_R4: assert property (@(posedge clk) disable iff (rst)
    br_q < 2'd2);
  assert_noop_term_R8: assert property (@(posedge clk) disable iff (rst)
    (noop_valid && term_mode) |=> (slot_q == '0 && br_q == '0));
  assert_noop_grow_R8: assert property (@(posedge clk) disable iff (rst)
    (noop_valid && !acc_valid && !term_mode && slot_q != 4'd6 && slot_q != 4'd15)
      |=> slot_q == $past(slot_q) + 4'd1);
  assert_restart_R5: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !noop_valid && acc_info.lead && slot_q != '0 && slot_q != 4'd5
     && !(acc_branch && br_q == 2'd1)) |=> mem_q == members_t'(1));
endmodule

// File: rtl/dgroup_tracker.sv
module dgroup_tracker
  import dgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cand_valid,
  input  logic [4:0]        cand_class,
  input  logic              cand_record,
  input  logic              cand_load,
  input  logic              cand_branch,
  input  logic              cand_conflict,
  input  logic              term_noop_mode,
  input  logic              acc_valid,
  input  logic [4:0]        acc_class,
  input  logic              acc_record,
  input  logic              acc_branch,
  input  logic              noop_valid,
  output logic              hazard,
  output logic              prefer_other,
  output logic [2:0]        filler_count,
  output logic [3:0]        slot_count,
  output logic [1:0]        branch_count,
  output logic [7:0]        member_mask
);
  localparam int NPORTS = 2; // 0: candidate, 1: accept

  class_t    dec_cls [NPORTS];
  logic      dec_rec [NPORTS];
  logic      dec_en  [NPORTS];
  cls_info_t dec_info[NPORTS];

  assign dec_cls[0] = cand_class;
  assign dec_rec[0] = cand_record;
  assign dec_en[0]  = cand_valid;
  assign dec_cls[1] = acc_class;
  assign dec_rec[1] = acc_record;
  assign dec_en[1]  = acc_valid;

  for (genvar p = 0; p < NPORTS; p++) begin : g_dec
    dgt_class_decode u_dec (
      .clk    (clk),
      .rst    (rst),
      .en     (dec_en[p]),
      .cls    (dec_cls[p]),
      .record (dec_rec[p]),
      .info   (dec_info[p])
    );
  end

  slot_t           slot_q;
  logic [BR_W-1:0] br_q;
  members_t        mem_q;

  dgt_group_state u_state (
    .clk        (clk),
    .rst        (rst),
    .term_mode  (term_noop_mode),
    .acc_valid  (acc_valid),
    .acc_branch (acc_branch),
    .acc_info   (dec_info[1]),
    .noop_valid (noop_valid),
    .slot_q     (slot_q),
    .br_q       (br_q),
    .mem_q      (mem_q)
  );

  dgt_filler_calc u_fill (
    .clk           (clk),
    .rst           (rst),
    .slot          (slot_q),
    .cand_valid    (cand_valid),
    .cand_load     (cand_load),
    .cand_branch   (cand_branch),
    .cand_conflict (cand_conflict),
    .term_mode     (term_noop_mode),
    .hazard        (hazard),
    .filler        (filler_count)
  );

  assign prefer_other = cand_valid && dec_info[0].lead && (slot_q != '0);
  assign slot_count   = slot_q;
  assign branch_count = br_q;
  assign member_mask  = mem_q;

  assert_prefer_busy_R9: assert property (@(posedge clk) disable iff (rst)
    prefer_other |-> slot_count != '0);
endmodule

// File: tb/test_dgroup_tracker.sv
`timescale 1ns/1ps
module test_dgroup_tracker;
  logic clk = 1'b0;
  logic rst;
  logic cand_valid, cand_record, cand_load, cand_branch, cand_conflict, term_noop_mode;
  logic [4:0] cand_class, acc_class;
  logic acc_valid, acc_record, acc_branch, noop_valid;
  logic hazard, prefer_other;
  logic [2:0] filler_count;
  logic [3:0] slot_count;
  logic [1:0] branch_count;
  logic [7:0] member_mask;

  int n_checks = 0;
  int n_fail = 0;
  int m_slot = 0;
  int m_br = 0;
  logic [7:0] m_mem = '0;
  string prev_tag = "R11";

  always #2.5 clk = ~clk;

  dgroup_tracker i_dgroup_tracker (.*);

  function automatic int f_weight(input int c, input bit rec);
    int w;
    if (c >= 12 && c <= 20) w = 4;
    else if (c >= 1 && c <= 11) w = 2;
    else w = 1;
    if (rec && w == 1) w = 2;
    return w;
  endfunction

  function automatic bit f_lead(input int c, input bit rec);
    return (f_weight(c, rec) > 1) || (c >= 21 && c <= 24);
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic m_clear();
    m_slot = 0; m_br = 0; m_mem = '0;
  endtask

  task automatic step(input string tag, input bit r,
                      input bit cv, input int cc, input bit crec, input bit cl,
                      input bit cb, input bit ccf, input bit tm,
                      input bit av, input int ac, input bit arec, input bit ab,
                      input bit nv);
    int eh, ef, ep;
    @(negedge clk);
    #0.5;
    check(prev_tag, "slot_count", int'(slot_count), m_slot);
    check(prev_tag, "branch_count", int'(branch_count), m_br);
    check(prev_tag, "member_mask", int'(member_mask), int'(m_mem));
    rst = r; cand_valid = cv; cand_class = 5'(cc); cand_record = crec;
    cand_load = cl; cand_branch = cb; cand_conflict = ccf; term_noop_mode = tm;
    acc_valid = av; acc_class = 5'(ac); acc_record = arec; acc_branch = ab;
    noop_valid = nv;
    #1;
    eh = int'(cv && ccf && (cl || cb));
    ef = (eh != 0 && m_slot < 6) ? (tm ? 1 : 5 - m_slot) : 0;
    ep = int'(cv && f_lead(cc, crec) && m_slot != 0);
    check(tag, "hazard(R7)", int'(hazard), eh);
    check(tag, "filler_count(R7)", int'(filler_count), ef);
    check(tag, "prefer_other(R9)", int'(prefer_other), ep);
    @(posedge clk);
    if (r) m_clear();
    else begin
      if (av) begin
        if (m_slot == 5 || (ab && m_br == 1)) m_clear();
        else begin
          if (f_lead(ac, arec) && m_slot != 0) m_clear();
          m_slot = m_slot + f_weight(ac, arec);
          if (m_slot > 15) m_slot = 15;
          m_mem = {m_mem[6:0], 1'b1};
          if (ab) m_br++;
        end
      end
      if (nv) begin
        if (tm || m_slot == 6) m_clear();
        else begin
          m_slot = (m_slot == 15) ? 15 : m_slot + 1;
          m_mem = {m_mem[6:0], 1'b1};
        end
      end
    end
    prev_tag = tag;
  endtask

  // accept-only shorthand
  task automatic acc(input string tag, input int c, input bit rec, input bit br);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 1, c, rec, br, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog (R11 run) actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1; cand_valid = 0; cand_class = 0; cand_record = 0; cand_load = 0;
    cand_branch = 0; cand_conflict = 0; term_noop_mode = 0; acc_valid = 0;
    acc_class = 0; acc_record = 0; acc_branch = 0; noop_valid = 0;
    repeat (3) @(posedge clk);
    m_clear();
    // R11: reset state checked at the first step
    step("R11", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    acc("R6", 0, 0, 0);                 // slot 1
    acc("R6", 30, 0, 0);                // slot 2
    step("R9", 0, 1, 21, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0); // R3 lead cand at 2 -> prefer; slot 3
    acc("R5", 3, 0, 0);                 // R1 weight 2, restart -> 2
    acc("R1", 15, 0, 0);                // weight 4 restart -> 4
    acc("R6", 0, 0, 0);                 // 5
    step("R4", 0, 1, 0, 0, 1, 0, 1, 0, 1, 0, 0, 0, 0); // filler 0 at 5; accept closes
    acc("R2", 0, 1, 0);                 // record -> 2
    acc("R6", 0, 0, 1);                 // branch -> 3, br 1
    step("R7", 0, 1, 0, 0, 0, 1, 1, 0, 1, 0, 0, 1, 0); // filler 2; second branch closes
    for (int k = 0; k < 5; k++) acc("R6", 0, 0, 0);
    step("R8", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1); // 5 -> 6
    step("R8", 0, 1, 0, 0, 1, 0, 1, 0, 0, 0, 0, 0, 1); // 6: filler 0; noop closes
    acc("R6", 0, 0, 0);
    step("R7", 0, 1, 0, 0, 1, 0, 1, 1, 0, 0, 0, 0, 1); // term filler 1; noop closes
    step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 1, 15, 0, 0, 1); // 4 then 5
    step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 1);  // close, then 1
    step("R3", 0, 1, 24, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);  // lead class 24 prefer
    step("R11", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 6000; i++) begin
      bit tm;
      tm = ((i / 200) % 2) == 1;
      step("R6", ($urandom % 500) == 0,
           ($urandom % 4) != 0, int'($urandom % 32), ($urandom % 5) == 0,
           ($urandom % 2) == 0, ($urandom % 4) == 0, ($urandom % 3) == 0, tm,
           ($urandom % 5) < 3, int'($urandom % 32), ($urandom % 5) == 0,
           ($urandom % 5) == 0, ($urandom % 6) == 0);
    end
    step("R6", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule